// File: doc/BRIEF.md
# PWM Fault Recovery Controller

This block watches a set of fault inputs that protect a PWM power stage and produces the enable mask for the PWM outputs. Each fault input goes through a short stability filter. A rising edge of the filtered level sets a sticky flag, and software clears that flag by writing one. A programmable map says which PWM outputs each fault shuts off. A raw fault level gates its mapped outputs at once, without passing through a register. The filter output also sets a per-fault latched disable, which holds the outputs off after the raw input has gone away.

The latched disable is released only when the PWM counter signals a recovery boundary and the fault's recovery rule is met. The rule is set per fault. Automatic recovery waits for the filtered level to clear. Manual normal recovery waits for the flag to clear. Manual safe recovery waits for both. A global select decides whether half-cycle strobes count as boundaries or only full-cycle strobes do. The block raises an interrupt request while any flag is set and that fault's interrupt enable is on. The interrupt enables have no effect on the protection path.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, all filtered levels, flags and latched disables are 0. Every output enable is 1 and the interrupt request is 0.
- R2: A filtered level takes a new value only after the raw input has shown that value on 3 consecutive clock edges. It changes on the third of those edges. A pulse of 2 clocks or fewer is ignored.
- R3: A flag is set on the edge where its filtered level rises. It is cleared on an edge where `flag_clr_i` has a 1 in that bit position. If a set and a clear fall on the same edge, the set wins.
- R4: Output o is disabled in the same cycle that a raw fault f is high, when map bit `dis_map_i[f*NUM_OUTS+o]` is 1. Outputs whose map bit is 0 for that fault are not affected by it.
- R5: In manual normal mode (`auto_clr_i[f]`=0, `safe_mode_i[f]`=0), the latched disable clears at a boundary when the flag is already 0, even if the filtered level is still 1.
- R6: In manual safe mode (`auto_clr_i[f]`=0, `safe_mode_i[f]`=1), the latched disable clears at a boundary only when the flag and the filtered level are both 0.
- R7: In automatic mode (`auto_clr_i[f]`=1), the latched disable clears at a boundary when the filtered level is 0, whatever the flag holds.
- R8: When `full_cycle_only_i`=1, only `full_strobe_i` forms a boundary. When it is 0, `half_strobe_i` forms a boundary as well.
- R9: A latched disable is set on the same edge as its flag. It never clears on an edge that is not a boundary.
- R10: `irq_o` is the OR over faults of (flag AND `irq_en_i`). Disabling works the same whatever `irq_en_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fault_raw_i | input | NUM_FAULTS | Raw fault levels, active high |
| auto_clr_i | input | NUM_FAULTS | 1 selects automatic recovery for that fault |
| safe_mode_i | input | NUM_FAULTS | In manual recovery, 1 selects safe mode |
| irq_en_i | input | NUM_FAULTS | Interrupt enable per fault |
| full_cycle_only_i | input | 1 | 1 means only full-cycle strobes are boundaries |
| half_strobe_i | input | 1 | Half-cycle boundary strobe from the counter |
| full_strobe_i | input | 1 | Full-cycle boundary strobe from the counter |
| flag_clr_i | input | NUM_FAULTS | Write-one-to-clear pulses for the flags |
| dis_map_i | input | NUM_FAULTS*NUM_OUTS | Disable map, bit f*NUM_OUTS+o links fault f to output o |
| pin_status_o | output | NUM_FAULTS | Filtered fault levels |
| flag_o | output | NUM_FAULTS | Sticky fault flags |
| out_en_o | output | NUM_OUTS | Output enables, 1 lets the PWM output drive |
| irq_o | output | 1 | Fault interrupt request |

## Verification
Two things can land on the same clock edge: the filtered rising edge that sets a flag, and the software write that clears that flag. A second pair is a boundary strobe that arrives while the filtered level is still settling. The bench holds the clear pulse through a whole filter ramp so that the set and the clear meet on one edge, and it expects the flag to remain 1. It also clears a flag and strobes a boundary while the filter still shows a fault. It then expects only manual normal mode to re-enable on that edge. Random runs mix strobes, clears and toggling faults, and every cycle is compared against a reference model kept in the bench.

// File: rtl/pfg_pkg.sv
// Shared definitions for the PWM fault recovery controller.
package pfg_pkg;
    // Recovery policy selected per fault channel.
    typedef enum logic [1:0] {
        REC_MANUAL_NORMAL = 2'd0,
        REC_MANUAL_SAFE   = 2'd1,
        REC_AUTO          = 2'd2
    } rec_policy_e;

    // Decode the two configuration bits into a policy.
    function automatic rec_policy_e decode_policy(input logic auto_clr, input logic safe);
        if (auto_clr)  return REC_AUTO;
        else if (safe) return REC_MANUAL_SAFE;
        else           return REC_MANUAL_NORMAL;
    endfunction
endpackage

// File: rtl/pfg_filter.sv
// Stability filter for one fault input.
// The filtered level follows the raw input once the raw input has differed
// from it on DEPTH consecutive edges. rise_o pulses (combinationally) in the
// cycle in which the filtered level is about to go from 0 to 1.
// Assumes raw_i is already synchronous to clk.
module pfg_filter #(
    parameter int unsigned DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o,
    output logic rise_o
);
    localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;
    logic          differ;
    logic          commit;

    assign differ = raw_i ^ filt_q;
    assign commit = differ && (cnt_q == LAST);
    assign rise_o = commit && raw_i;
    assign filt_o = filt_q;

    // Count consecutive disagreeing edges and commit the new level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (commit) begin
            cnt_q  <= '0;
            filt_q <= raw_i;
        end else if (differ) begin
            cnt_q  <= cnt_q + 1'b1;
        end else begin
            cnt_q  <= '0;
        end
    end
endmodule

// File: rtl/pfg_channel.sv
// One fault channel: filter, sticky flag and latched output disable.
// The flag is set on a filtered rise and cleared by a write-one pulse. If both
// come on the same edge, the set wins. The latched disable is set together
// with the flag. It is released on a boundary edge once the recovery policy's
// condition holds, and that condition is read from the current register state.
module pfg_channel
    import pfg_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic auto_clr_i,
    input  logic safe_i,
    input  logic clr_i,
    input  logic boundary_i,
    output logic filt_o,
    output logic flag_o,
    output logic lat_o
);
    logic        rise;
    logic        flag_q;
    logic        lat_q;
    logic        release_ok;
    rec_policy_e policy;

    pfg_filter #(.DEPTH(DEPTH)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_i),
        .filt_o (filt_o),
        .rise_o (rise)
    );

    assign policy = decode_policy(auto_clr_i, safe_i);

    // Work out whether this channel's recovery condition holds now.
    always_comb begin
        unique case (policy)
            REC_AUTO:        release_ok = !filt_o;
            REC_MANUAL_SAFE: release_ok = !flag_q && !filt_o;
            default:         release_ok = !flag_q;
        endcase
    end

    // Sticky flag: set wins over the write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (rise)   flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    // Latched disable: set with the flag, released only on a qualifying boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                        lat_q <= 1'b0;
        else if (rise)                     lat_q <= 1'b1;
        else if (boundary_i && release_ok) lat_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign lat_o  = lat_q;
endmodule

// File: rtl/pfg_gate.sv
// Output gating: an output is disabled if any fault that maps to it has
// either its latched disable or its raw input set. Purely combinational.
module pfg_gate #(
    parameter int unsigned NF = 4,
    parameter int unsigned NO = 8
) (
    input  logic [NF*NO-1:0] map_i,
    input  logic [NF-1:0]    raw_i,
    input  logic [NF-1:0]    lat_i,
    output logic [NO-1:0]    en_o
);
    logic [NF-1:0][NO-1:0] kill;

    for (genvar f = 0; f < NF; f++) begin : g_fault
        // Outputs this fault currently shuts off.
        assign kill[f] = map_i[f*NO +: NO] & {NO{raw_i[f] | lat_i[f]}};
    end

    // Reduce the per-fault kill masks into one enable vector.
    always_comb begin
        en_o = '1;
        for (int f = 0; f < NF; f++) begin
            en_o = en_o & ~kill[f];
        end
    end
endmodule

// File: rtl/pwm_fault_guard.sv
// PWM fault recovery controller top.
// Instantiates one channel per fault, forms the recovery boundary from the
// counter strobes, gates the outputs and drives the interrupt request.
// Assumes all inputs are synchronous to clk and the strobes are one-cycle pulses.
module pwm_fault_guard #(
    parameter int unsigned NUM_FAULTS = 4,
    parameter int unsigned NUM_OUTS   = 8,
    parameter int unsigned FILT_DEPTH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_FAULTS-1:0]        fault_raw_i,
    input  logic [NUM_FAULTS-1:0]        auto_clr_i,
    input  logic [NUM_FAULTS-1:0]        safe_mode_i,
    input  logic [NUM_FAULTS-1:0]        irq_en_i,
    input  logic                         full_cycle_only_i,
    input  logic                         half_strobe_i,
    input  logic                         full_strobe_i,
    input  logic [NUM_FAULTS-1:0]        flag_clr_i,
    input  logic [NUM_FAULTS*NUM_OUTS-1:0] dis_map_i,
    output logic [NUM_FAULTS-1:0]        pin_status_o,
    output logic [NUM_FAULTS-1:0]        flag_o,
    output logic [NUM_OUTS-1:0]          out_en_o,
    output logic                         irq_o
);
    logic                  boundary;
    logic [NUM_FAULTS-1:0] lat_dis;

    // A half strobe counts only when full-cycle-only recovery is off.
    assign boundary = full_strobe_i || (half_strobe_i && !full_cycle_only_i);

    for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_ch
        pfg_channel #(.DEPTH(FILT_DEPTH)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_i      (fault_raw_i[f]),
            .auto_clr_i (auto_clr_i[f]),
            .safe_i     (safe_mode_i[f]),
            .clr_i      (flag_clr_i[f]),
            .boundary_i (boundary),
            .filt_o     (pin_status_o[f]),
            .flag_o     (flag_o[f]),
            .lat_o      (lat_dis[f])
        );
    end

    pfg_gate #(.NF(NUM_FAULTS), .NO(NUM_OUTS)) u_gate (
        .map_i (dis_map_i),
        .raw_i (fault_raw_i),
        .lat_i (lat_dis),
        .en_o  (out_en_o)
    );

    // Interrupt request: any flagged fault whose interrupt is enabled.
    assign irq_o = |(flag_o & irq_en_i);
endmodule

// File: rtl/pwm_fault_guard_chk.sv
// Assertion checker for pwm_fault_guard, attached by bind below.
// Boundary and raw kill mask are rebuilt here from the ports.
module pwm_fault_guard_chk #(
    parameter int unsigned NF    = 4,
    parameter int unsigned NO    = 8,
    parameter int unsigned DEPTH = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NF-1:0] fault_raw_i,
    input logic [NF-1:0] flag_clr_i,
    input logic [NF-1:0] irq_en_i,
    input logic          full_cycle_only_i,
    input logic          half_strobe_i,
    input logic          full_strobe_i,
    input logic [NF*NO-1:0] dis_map_i,
    input logic [NF-1:0] pin_status_o,
    input logic [NF-1:0] flag_o,
    input logic [NO-1:0] out_en_o,
    input logic          irq_o,
    input logic [NF-1:0] lat_dis
);
    logic          bnd;
    logic [NO-1:0] raw_kill;

    assign bnd = full_strobe_i | (half_strobe_i & ~full_cycle_only_i);

    // Outputs that some currently high raw fault maps to.
    always_comb begin
        raw_kill = '0;
        for (int f = 0; f < NF; f++) begin
            if (fault_raw_i[f]) raw_kill = raw_kill | dis_map_i[f*NO +: NO];
        end
    end

    // R3: a flag that is set and not cleared stays set.
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & $past(flag_o & ~flag_clr_i)) == $past(flag_o & ~flag_clr_i)));

    // R4: a raw fault forces its mapped outputs off in the same cycle.
    assert_raw_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_o & raw_kill) == '0);

    // R10: the interrupt request tracks enabled flags.
    assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(flag_o & irq_en_i));

    // R9: no latched disable is released on an edge that is not a boundary.
    assert_no_release_off_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> ((lat_dis & $past(lat_dis)) == $past(lat_dis)));

    // R9: a latched disable is set on the same edge as its flag.
    assert_latch_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat_dis & ($past(~flag_o) & flag_o)) == ($past(~flag_o) & flag_o)));

    if (DEPTH == 3) begin : g_filt_chk
        // R2: a filtered bit changes only after three agreeing raw samples.
        assert_filter_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (((pin_status_o ^ $past(pin_status_o)) &
                       ($past(fault_raw_i, 1) ^ pin_status_o)) == '0));
        assert_filter_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (((pin_status_o ^ $past(pin_status_o)) &
                       (($past(fault_raw_i, 2) ^ pin_status_o) |
                        ($past(fault_raw_i, 3) ^ pin_status_o))) == '0));
    end
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(
    .NF(NUM_FAULTS), .NO(NUM_OUTS), .DEPTH(FILT_DEPTH)
) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .fault_raw_i       (fault_raw_i),
    .flag_clr_i        (flag_clr_i),
    .irq_en_i          (irq_en_i),
    .full_cycle_only_i (full_cycle_only_i),
    .half_strobe_i     (half_strobe_i),
    .full_strobe_i     (full_strobe_i),
    .dis_map_i         (dis_map_i),
    .pin_status_o      (pin_status_o),
    .flag_o            (flag_o),
    .out_en_o          (out_en_o),
    .irq_o             (irq_o),
    .lat_dis           (lat_dis)
);

// File: tb/pwm_fault_guard_tb_top.sv
// Bench for pwm_fault_guard: directed corners plus seeded random traffic,
// compared each cycle with a reference model built from the requirements.
module pwm_fault_guard_tb_top;
    localparam int NF = 4;
    localparam int NO = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG_CYC = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] raw = '0, auto_clr = '0, safe = '0, irq_en = '0, clr = '0;
    logic          full_only = 1'b0, half_stb = 1'b0, full_stb = 1'b0;
    logic [NF*NO-1:0] map = '0;
    logic [NF-1:0] pin, flag;
    logic [NO-1:0] out_en;
    logic          irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R9";

    // Reference model state.
    logic [NF-1:0] m_filt = '0, m_flag = '0, m_lat = '0;
    int            m_cnt [NF];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_fault_guard #(.NUM_FAULTS(NF), .NUM_OUTS(NO), .FILT_DEPTH(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .fault_raw_i(raw), .auto_clr_i(auto_clr),
        .safe_mode_i(safe), .irq_en_i(irq_en), .full_cycle_only_i(full_only),
        .half_strobe_i(half_stb), .full_strobe_i(full_stb), .flag_clr_i(clr),
        .dis_map_i(map), .pin_status_o(pin), .flag_o(flag), .out_en_o(out_en),
        .irq_o(irq)
    );

    // Model update on each edge, following R2, R3, R5-R9.
    always @(posedge clk) begin
        logic bnd, rise, cond;
        bnd = full_stb | (half_stb & ~full_only);
        for (int f = 0; f < NF; f++) begin
            if (!rst_n) begin
                m_filt[f] = 1'b0; m_flag[f] = 1'b0; m_lat[f] = 1'b0; m_cnt[f] = 0;
            end else begin
                rise = 1'b0;
                if (auto_clr[f])  cond = ~m_filt[f];
                else if (safe[f]) cond = ~m_flag[f] & ~m_filt[f];
                else              cond = ~m_flag[f];
                if (raw[f] != m_filt[f]) begin
                    if (m_cnt[f] == 2) begin
                        m_filt[f] = raw[f]; m_cnt[f] = 0; rise = raw[f];
                    end else m_cnt[f] = m_cnt[f] + 1;
                end else m_cnt[f] = 0;
                m_flag[f] = rise | (m_flag[f] & ~clr[f]);
                m_lat[f]  = rise | (m_lat[f] & ~(bnd & cond));
            end
        end
    end

    function automatic logic [NO-1:0] exp_en();
        logic [NO-1:0] e = '1;
        for (int f = 0; f < NF; f++)
            if (m_lat[f] | raw[f]) e = e & ~map[f*NO +: NO];
        return e;
    endfunction

    function automatic logic exp_irq();
        return |(m_flag & irq_en);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 filtered level", 32'(pin), 32'(m_filt));
        chk("R3 flag", 32'(flag), 32'(m_flag));
        chk("R10 irq", 32'(irq), 32'(exp_irq()));
        chk({cur_tag, " out_en"}, 32'(out_en), 32'(exp_en()));
    endtask

    // One clock: edge, then compare away from the edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic settle();
        raw = '0; clr = '1; full_stb = 1'b1;
        repeat (6) tick();
        clr = '0; full_stb = 1'b0;
        tick();
    endtask

    // Flag and latch one fault, then try to recover it in a given mode.
    task automatic recover_case(input int ch, input logic a, input logic s,
                                input logic do_clr, input string tag);
        cur_tag = tag;
        auto_clr = '0; safe = '0; auto_clr[ch] = a; safe[ch] = s;
        full_only = 1'b0;
        map = '0; map[ch*NO +: NO] = 8'h0F;
        raw[ch] = 1'b1;
        repeat (4) tick();
        raw[ch] = 1'b0; clr[ch] = do_clr; half_stb = 1'b1;
        tick();
        clr = '0;
        tick();
        // Flag clear, filter still reporting a fault: only manual normal re-enables.
        chk({tag, " early release"}, 32'(out_en & 8'h0F),
            (!a && !s) ? 32'h0F : 32'h00);
        repeat (2) tick();
        chk({tag, " late release"}, 32'(out_en & 8'h0F), 32'h0F);
        if (a) chk({tag, " flag kept"}, 32'(flag[ch]), 32'd1);
        half_stb = 1'b0;
        settle();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int f = 0; f < NF; f++) m_cnt[f] = 0;
        map = {NF*NO{1'b1}}; irq_en = '1;
        raw = 4'b0101;
        repeat (3) @(negedge clk);
        raw = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1 filtered", 32'(pin), 32'd0);
        chk("R1 flag", 32'(flag), 32'd0);
        chk("R1 out_en", 32'(out_en), 32'hFF);
        chk("R1 irq", 32'(irq), 32'd0);

        // R2: a two-cycle glitch is filtered out.
        cur_tag = "R2";
        raw[0] = 1'b1; tick(); tick();
        raw[0] = 1'b0; tick(); tick(); tick();
        chk("R2 glitch", 32'(pin[0]), 32'd0);
        // R2: three agreeing samples pass.
        raw[0] = 1'b1; tick(); tick();
        chk("R2 before third", 32'(pin[0]), 32'd0);
        tick();
        chk("R2 third edge", 32'(pin[0]), 32'd1);
        settle();

        // R4: raw fault gates mapped outputs in the same cycle, not others.
        cur_tag = "R4";
        map = '0; map[1*NO +: NO] = 8'h0F;
        raw[1] = 1'b1;
        #1;
        chk("R4 combinational gate", 32'(out_en), 32'hF0);
        tick();
        settle();

        // R3 + R10: set and clear on the same edge, set wins; irq follows enable.
        cur_tag = "R3";
        irq_en = 4'b0100; map = '0;
        raw[2] = 1'b1; clr[2] = 1'b1;
        repeat (3) tick();
        chk("R3 set wins", 32'(flag[2]), 32'd1);
        chk("R10 irq on", 32'(irq), 32'd1);
        tick();
        chk("R3 write-one clear", 32'(flag[2]), 32'd0);
        clr = '0; irq_en = '0;
        raw[3] = 1'b1; map[3*NO +: NO] = 8'hC0;
        repeat (4) tick();
        chk("R10 irq masked", 32'(irq), 32'd0);
        chk("R10 protection independent of enable", 32'(out_en & 8'hC0), 32'd0);
        settle();

        recover_case(0, 1'b0, 1'b0, 1'b1, "R5");
        recover_case(1, 1'b0, 1'b1, 1'b1, "R6");
        recover_case(2, 1'b1, 1'b0, 1'b0, "R7");

        // R8: with full-cycle-only, half strobes do not release.
        cur_tag = "R8";
        auto_clr = '1; full_only = 1'b1; map = '0; map[0 +: NO] = 8'hFF;
        raw[0] = 1'b1; repeat (4) tick();
        raw[0] = 1'b0; repeat (4) tick();
        half_stb = 1'b1; tick(); half_stb = 1'b0;
        chk("R8 half ignored", 32'(out_en), 32'h00);
        chk("R9 held without boundary", 32'(out_en), 32'h00);
        full_stb = 1'b1; tick(); full_stb = 1'b0;
        chk("R8 full releases", 32'(out_en), 32'hFF);
        settle();

        // Random traffic checked every cycle.
        cur_tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            if (i % 64 == 0) begin
                auto_clr = 4'($urandom); safe = 4'($urandom); irq_en = 4'($urandom);
                full_only = 1'($urandom); map = 32'($urandom);
            end
            for (int f = 0; f < NF; f++)
                if ($urandom_range(7) == 0) raw[f] = ~raw[f];
            half_stb = ($urandom_range(5) == 0);
            full_stb = ($urandom_range(11) == 0);
            for (int f = 0; f < NF; f++) clr[f] = ($urandom_range(9) == 0);
            tick();
        end
        half_stb = 1'b0; full_stb = 1'b0; clr = '0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule